// File: doc/BRIEF.md
# Presentation Timestamp Stepper with Drift Correction

This block produces the 16-bit presentation time carried in the first packet header of every video frame in an isochronous stream. The value is split into two fields with different bases. The top 4 bits count bus cycles modulo 16. The low 12 bits hold a sub-cycle offset that runs modulo 3072. On each frame strobe the timestamp moves forward by one frame period. That period is an exact fraction of a cycle offset, so a numerator/denominator accumulator spreads the remainder across frames, and any overflow of the offset field carries into the cycle field.

Each new timestamp is also compared with the most recently captured transmit time. The comparison looks only at the cycle fields and is done modulo 16. If the stamp has moved too far ahead of that time or fallen too close to it, the stamp is moved by one whole cycle. The corrected value then becomes the base for the next frame, which keeps the presentation time a fixed two to three cycles ahead of bus time. A start pulse reloads the stamp with a chosen initial cycle count and clears the offset and accumulator state.

Top module: `syt_stamp_gen`

## Requirements
- R1: After reset, `syt` is 0x2000 (cycle field 2, offset 0). In the cycle after `start` is high, `syt` equals `{init_cycles, 12'h000}` and neither adjustment pulse is high. `start` also reloads the accumulator with N.
- R2: On each `frame` cycle, N (0xB34) is added to the accumulator. If the sum is strictly greater than D (0x23028), the offset advances by I+1 and D is subtracted from the accumulator. Otherwise the offset advances by I (0xB34).
- R3: The offset field `syt[11:0]` is always below 3072.
- R4: When the advanced offset reaches 3072 or more, 3072 is subtracted from it and one is added to the cycle field.
- R5: On each `frame` cycle, the cycle field `syt[15:12]` advances by 10 modulo 16, before any carry or correction is applied.
- R6: The drift is the stepped cycle field minus `tx_stamp[15:12]`, taken modulo 16 as a signed 4-bit value in the range -8..7. If the drift is greater than the signed `lim_hi`, the cycle field is decremented by one and `adj_dn` pulses for one cycle.
- R7: If the drift is not above `lim_hi` and is below the signed `lim_lo`, the cycle field is incremented by one and `adj_up` pulses for one cycle.
- R8: A drift inside [`lim_lo`, `lim_hi`] changes nothing and raises no pulse. At most one correction is made per frame. The pulses are never high together, and they appear only in the cycle after a `frame` strobe.
- R9: While neither `start` nor `frame` is high, `syt` holds its value.
- R10: When `start` and `frame` are high in the same cycle, `start` wins and no step is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Reload the stamp from `init_cycles` |
| init_cycles | input | 4 | Initial cycle field for the stamp |
| frame | input | 1 | One-cycle strobe per video frame |
| tx_stamp | input | 16 | Most recently captured transmit time |
| lim_hi | input | 4 | Signed upper drift limit, in cycles |
| lim_lo | input | 4 | Signed lower drift limit, in cycles |
| syt | output | 16 | Presentation timestamp, cycle count in the top 4 bits |
| adj_up | output | 1 | Pulse: the stamp was moved one cycle later |
| adj_dn | output | 1 | Pulse: the stamp was moved one cycle earlier |

## Verification
The embedded assertions check the following on every cycle:
- The offset stays below 3072.
- Each frame moves the offset by exactly I or I+1 modulo 3072.
- The change in the cycle field equals the base step, plus the offset carry, plus or minus any signalled correction.
- The two pulses are exclusive and follow only a frame strobe.
- The stamp holds between strobes, and a start reloads it.

Some behaviour only the bench's scenarios can show. The first is which of I or I+1 is chosen on a given frame, which follows from the long-run accumulator sequence across hundreds of frames. The second is whether a given transmit time and pair of limits leads to the right correction, including drifts that wrap past the 4-bit boundary.

// File: rtl/syt_stamp_gen.sv
module syt_stamp_gen #(
  parameter int unsigned STEP_I       = 'hB34,
  parameter int unsigned STEP_N       = 'hB34,
  parameter int unsigned STEP_D       = 'h23028,
  parameter int unsigned ACC_W        = 18,
  parameter int unsigned OFS_MOD      = 3072,
  parameter int unsigned CYC_STEP     = 10,
  parameter int unsigned RESET_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        init_cycles,
  input  logic              frame,
  input  logic [15:0]       tx_stamp,
  input  logic signed [3:0] lim_hi,
  input  logic signed [3:0] lim_lo,
  output logic [15:0]       syt,
  output logic              adj_up,
  output logic              adj_dn
);

  localparam logic [ACC_W:0]   ACC_ADD = (ACC_W+1)'(STEP_N);
  localparam logic [ACC_W:0]   ACC_LIM = (ACC_W+1)'(STEP_D);
  localparam logic [ACC_W-1:0] ACC_INI = ACC_W'(STEP_N);
  localparam logic [12:0]      OFS_ADD = 13'(STEP_I);
  localparam logic [12:0]      OFS_TOP = 13'(OFS_MOD);
  localparam logic [3:0]       CYC_ADD = 4'(CYC_STEP);
  localparam logic [3:0]       CYC_RST = 4'(RESET_CYCLES);

  logic [3:0]       cyc_q;
  logic [11:0]      ofs_q;
  logic [ACC_W-1:0] acc_q;

  logic [ACC_W:0] acc_sum;
  logic           carry;
  logic [12:0]    ofs_sum;
  logic           wrap;
  logic [3:0]     cyc_step;
  logic signed [3:0] drift;
  logic           too_far, too_near;

  assign acc_sum  = {1'b0, acc_q} + ACC_ADD;
  assign carry    = acc_sum > ACC_LIM;
  assign ofs_sum  = {1'b0, ofs_q} + OFS_ADD + {12'b0, carry};
  assign wrap     = ofs_sum >= OFS_TOP;
  assign cyc_step = cyc_q + CYC_ADD + {3'b0, wrap};
  assign drift    = signed'(cyc_step - tx_stamp[15:12]);
  assign too_far  = drift > lim_hi;
  assign too_near = !too_far && (drift < lim_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= CYC_RST;
      ofs_q  <= '0;
      acc_q  <= ACC_INI;
      adj_up <= 1'b0;
      adj_dn <= 1'b0;
    end else begin
      adj_up <= 1'b0;
      adj_dn <= 1'b0;
      if (start) begin
        cyc_q <= init_cycles;
        ofs_q <= '0;
        acc_q <= ACC_INI;
      end else if (frame) begin
        acc_q  <= carry ? ACC_W'(acc_sum - ACC_LIM) : acc_sum[ACC_W-1:0];
        ofs_q  <= wrap ? 12'(ofs_sum - OFS_TOP) : ofs_sum[11:0];
        cyc_q  <= cyc_step - {3'b0, too_far} + {3'b0, too_near};
        adj_dn <= too_far;
        adj_up <= too_near;
      end
    end
  end

  assign syt = {cyc_q, ofs_q};

  function automatic logic [12:0] ofs_gap(logic [11:0] now, logic [11:0] was);
    logic [12:0] t;
    t = {1'b0, now} + OFS_TOP - {1'b0, was};
    return (t >= OFS_TOP) ? t - OFS_TOP : t;
  endfunction

  assert_ofs_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ofs_q} < OFS_TOP);

  assert_ofs_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame && !start |=> (ofs_gap(ofs_q, $past(ofs_q)) == OFS_ADD) ||
                        (ofs_gap(ofs_q, $past(ofs_q)) == OFS_ADD + 13'd1));

  assert_cyc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame && !start |=> cyc_q == 4'($past(cyc_q) + CYC_ADD + {3'b0, ofs_q < $past(ofs_q)}
                                    + {3'b0, adj_up} - {3'b0, adj_dn}));

  assert_adj_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({adj_up, adj_dn}));

  assert_adj_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adj_up || adj_dn |-> $past(frame && !start));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !frame |=> $stable(syt));

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> syt == {$past(init_cycles), 12'h000} && !adj_up && !adj_dn);

endmodule

// File: tb/tb_syt_stamp_gen.sv
`timescale 1ns/1ps
module tb_syt_stamp_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] init_cycles = 4'd0;
  logic frame = 1'b0;
  logic [15:0] tx_stamp = 16'd0;
  logic signed [3:0] lim_hi = 4'sd3;
  logic signed [3:0] lim_lo = 4'sd2;
  logic [15:0] syt;
  logic adj_up, adj_dn;

  int checks = 0;
  int errors = 0;

  int m_cyc = 2, m_ofs = 0, m_acc = 'hB34;

  logic [17:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  syt_stamp_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .init_cycles(init_cycles),
    .frame(frame), .tx_stamp(tx_stamp), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .syt(syt), .adj_up(adj_up), .adj_dn(adj_dn)
  );

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual syt=%h up=%b dn=%b expected syt=%h up=%b dn=%b",
               req, act[17:2], act[1], act[0], exp[17:2], exp[1], exp[0]);
    end
  endtask

  task automatic do_frame(int want, int hi, int lo);
    int sc, d, tcyc;
    logic up, dn;
    string tag;
    m_acc += 'hB34;
    if (m_acc > 'h23028) begin m_ofs += 'hB35; m_acc -= 'h23028; end
    else m_ofs += 'hB34;
    sc = m_cyc + 10;
    if (m_ofs >= 3072) begin m_ofs -= 3072; sc++; end
    sc &= 15;
    tcyc = (sc - want) & 15;
    d = (sc - tcyc) & 15;
    if (d >= 8) d -= 16;
    up = 1'b0; dn = 1'b0; tag = "R2 R3 R4 R5 R8";
    if (d > hi) begin dn = 1'b1; sc = (sc + 15) & 15; tag = "R6"; end
    else if (d < lo) begin up = 1'b1; sc = (sc + 1) & 15; tag = "R7"; end
    m_cyc = sc;
    exp_q.push_back({4'(m_cyc), 12'(m_ofs), up, dn});
    tag_q.push_back(tag);
    @(negedge clk);
    frame = 1'b1;
    tx_stamp = {4'(tcyc), 12'($urandom_range(0, 3071))};
    lim_hi = 4'(hi);
    lim_lo = 4'(lo);
    @(negedge clk);
    frame = 1'b0;
  endtask

  task automatic do_start(int cyc, bit with_frame);
    @(negedge clk);
    start = 1'b1;
    init_cycles = 4'(cyc);
    frame = with_frame;
    @(negedge clk);
    start = 1'b0;
    frame = 1'b0;
    m_cyc = cyc; m_ofs = 0; m_acc = 'hB34;
    check(with_frame ? "R10" : "R1", {syt, adj_up, adj_dn}, {4'(cyc), 12'h000, 2'b00});
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (frame === 1'b1 && start !== 1'b1) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("R9", {syt, adj_up, adj_dn}, 18'h0);
        end else begin
          check(tag_q.pop_front(), {syt, adj_up, adj_dn}, exp_q.pop_front());
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1..watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R1", {syt, adj_up, adj_dn}, {16'h2000, 2'b00});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {syt, adj_up, adj_dn}, {16'h2000, 2'b00});
    do_start(2, 1'b0);
    for (int i = 0; i < 200; i++) do_frame(2 + (i % 2), 3, 2);
    do_frame(5, 3, 2);
    do_frame(0, 3, 2);
    do_frame(-1, 3, 2);
    do_frame(7, 3, 2);
    do_frame(8, 3, 2);
    do_frame(4, 3, 2);
    do_frame(1, 3, 2);
    do_frame(3, 3, 2);
    repeat (3) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R9", {syt, adj_up, adj_dn}, {4'(m_cyc), 12'(m_ofs), 2'b00});
    do_start(14, 1'b0);
    for (int i = 0; i < 60; i++) do_frame(3, 4, 1);
    do_frame(6, 4, 1);
    do_frame(0, 4, 1);
    do_start(5, 1'b1);
    repeat (5) @(negedge clk);
    check("R10", {syt, adj_up, adj_dn}, {4'd5, 12'h000, 2'b00});
    do_frame(2, 3, 2);
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule